// File: doc/BRIEF.md
# Host Interrupt Status and Coalescing Unit

This block gathers interrupt events from the rest of the chip and presents them to a host processor through four 32-bit registers and one interrupt line. Events land in two sticky status registers: a main status register and a DMA status register. The host clears a bit by writing a one to it. Three bits of the main status register are not stored; they summarise groups of DMA status bits. Reading a summary bit shows whether any bit in its group is set. The host clears a summary bit by clearing the DMA bits behind it.

A mask register selects which main status bits may raise the interrupt line. The first unmasked pending bit does not raise the line at once. It starts a coalescing wait of a programmable number of 32 µs units, so that later events join the same interrupt. One DMA bit marks a high-priority receive event. When that bit is set and the receive summary is unmasked, the line rises on the next clock and skips any wait. The host reaches all registers through a plain write strobe, an address and an asynchronous read mux.

The interrupt sequencer has three states:
- `ST_IDLE`: nothing is pending.
- `ST_HOLD`: the coalescing wait is running.
- `ST_FIRE`: the line is high.

The transitions are:
- IDLE→FIRE: a bit becomes pending and the coalescing value is zero, or the bypass is active.
- IDLE→HOLD: a bit becomes pending and the coalescing value is non-zero.
- HOLD→FIRE: the wait ends, or the bypass becomes active.
- HOLD→IDLE: nothing is pending any more.
- FIRE→IDLE: nothing is pending any more.

Top module: `host_irq_coalescer`

## Requirements
- R1: After reset, every register reads zero and `irq_o` is low.
- R2: Status bits are write-one-to-clear.
  - Writing a 1 clears the bit on the next clock; writing a 0 leaves the bit unchanged.
  - If a hardware event and a host clear hit the same bit in the same cycle, the bit ends up set.
  - A status bit changes only through an event or a clear.
- R3: A pulse on `evt_main_i` latches into main status at these positions:
  - bit 28: code download done;
  - bit 26: queue pointer advanced;
  - bit 25: firmware error;
  - bit 7: RF kill toggled;
  - bit 6: critical temperature;
  - bit 3: firmware receive;
  - bit 1: wakeup;
  - bit 0: alive.

  Every other non-summary main bit always reads 0.
- R4: DMA status stores these bits from `evt_dma_i`:
  - bit 31: DMA error;
  - bit 30: high-priority receive;
  - bits 16, 17 and 18: receive channels 0 to 2;
  - bits 0, 1 and 6: transmit channels.

  All other DMA bits read 0.
- R5: The main summary bits are derived from DMA status:
  - main bit 31 is the OR of DMA bits 30, 18, 17 and 16;
  - main bit 29 equals DMA bit 31;
  - main bit 27 is the OR of DMA bits 6, 1 and 0.

  Host writes to these three main bits have no effect.
- R6: The register offsets are:
  - 0x004: coalescing value, in the low `COAL_W` bits;
  - 0x008: main status;
  - 0x00C: mask;
  - 0x010: DMA status.

  The mask and coalescing registers read back what was written. Any other offset reads 0.
- R7: `irq_o` is high only while the previous cycle had a set, unmasked main status bit. It falls one cycle after the last such bit clears.
- R8: With a coalescing value of 0, `irq_o` rises on the clock edge after a pending unmasked bit first appears in status.
- R9: With a coalescing value of N > 0, `irq_o` rises N×`UNIT_CYCLES` cycles later than it would with 0.
- R10: When DMA bit 30 and mask bit 31 are both set, `irq_o` is high on the next cycle, whatever wait is running.
  - Without mask bit 31, DMA bit 30 follows the normal coalescing wait.
- R11: If all pending bits clear during a wait, the wait is abandoned. The next event starts a full wait again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| evt_main_i | input | 32 | One-cycle event pulses for main status bits |
| evt_dma_i | input | 32 | One-cycle event pulses for DMA status bits |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | ADDR_W | Register byte offset for reads and writes |
| reg_wdata_i | input | 32 | Write data |
| reg_rdata_o | output | 32 | Read data for `reg_addr_i` |
| irq_o | output | 1 | Interrupt line to the host |

## Verification
The bench builds the block with `UNIT_CYCLES` set to 4 and `COAL_W` left at 8. With these values, waits of several coalescing units take only a few tens of cycles. That makes it cheap to compare exact rise cycles for several values, to abandon waits part-way and to cut them short with the bypass. The default of 3200 cycles per unit, which is 32 µs at 100 MHz, would make the same walk thousands of cycles long without exercising any extra logic.

// File: rtl/hirq_pkg.sv
package hirq_pkg;

    // Register byte offsets; the host-side decoder depends on these.
    localparam int unsigned OFS_COAL = 32'h004;
    localparam int unsigned OFS_STAT = 32'h008;
    localparam int unsigned OFS_MASK = 32'h00C;
    localparam int unsigned OFS_DMA  = 32'h010;

    // Main status bits that hardware events may set.
    localparam logic [31:0] MAIN_EVT_BITS = 32'h1600_00CB;

    // DMA status groups.
    localparam logic [31:0] DMA_RX_GRP  = 32'h4007_0000;
    localparam logic [31:0] DMA_TX_GRP  = 32'h0000_0043;
    localparam logic [31:0] DMA_ERR_GRP = 32'h8000_0000;
    localparam logic [31:0] DMA_BITS    = DMA_RX_GRP | DMA_TX_GRP | DMA_ERR_GRP;

    // Summary positions in main status and the bypass bit in DMA status.
    localparam int SUM_RX   = 31;
    localparam int SUM_ERR  = 29;
    localparam int SUM_TX   = 27;
    localparam int HIPRI_RX = 30;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_HOLD = 2'd1,
        ST_FIRE = 2'd2
    } irq_state_t;

endpackage

// File: rtl/hirq_w1c_bank.sv
module hirq_w1c_bank #(
    parameter int          W    = 32,
    parameter logic [31:0] IMPL = 32'hFFFF_FFFF
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] set_i,
    input  logic [W-1:0] clr_i,
    output logic [W-1:0] q_o
);

    for (genvar i = 0; i < W; i++) begin : g_bit
        if (IMPL[i]) begin : g_ff
            logic bit_q;
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    bit_q <= 1'b0;
                end else begin
                    // set dominates a simultaneous clear
                    bit_q <= (bit_q & ~clr_i[i]) | set_i[i];
                end
            end
            assign q_o[i] = bit_q;
        end else begin : g_tie
            logic unused_in;
            assign unused_in = set_i[i] ^ clr_i[i];
            assign q_o[i]    = 1'b0;
        end
    end

endmodule

// File: rtl/hirq_coal_fsm.sv
module hirq_coal_fsm
    import hirq_pkg::*;
#(
    parameter int COAL_W      = 8,
    parameter int UNIT_CYCLES = 3200
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              pending_i,
    input  logic              bypass_i,
    input  logic [COAL_W-1:0] coal_i,
    output irq_state_t        state_o,
    output logic              irq_o
);

    localparam int UW = (UNIT_CYCLES > 1) ? $clog2(UNIT_CYCLES) : 1;

    irq_state_t        state_q, state_d;
    logic [UW-1:0]     cyc_q;
    logic [COAL_W-1:0] units_q;
    logic              unit_end, last_unit, expire;

    assign unit_end  = (cyc_q == UW'(UNIT_CYCLES - 1));
    assign last_unit = ({1'b0, units_q} + 1'b1) >= {1'b0, coal_i};
    assign expire    = unit_end && last_unit;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (pending_i)
                    state_d = (bypass_i || coal_i == '0) ? ST_FIRE : ST_HOLD;
            end
            ST_HOLD: begin
                if (!pending_i)               state_d = ST_IDLE;
                else if (bypass_i || expire)  state_d = ST_FIRE;
            end
            ST_FIRE: begin
                if (!pending_i) state_d = ST_IDLE;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // coalescing timer: runs only in HOLD, parked at zero elsewhere
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cyc_q   <= '0;
            units_q <= '0;
        end else if (state_q != ST_HOLD) begin
            cyc_q   <= '0;
            units_q <= '0;
        end else if (unit_end) begin
            cyc_q   <= '0;
            units_q <= units_q + 1'b1;
        end else begin
            cyc_q   <= cyc_q + 1'b1;
        end
    end

    // outputs
    always_comb begin
        irq_o   = (state_q == ST_FIRE);
        state_o = state_q;
    end

endmodule

// File: rtl/host_irq_coalescer.sv
module host_irq_coalescer
    import hirq_pkg::*;
#(
    parameter int ADDR_W      = 12,
    parameter int COAL_W      = 8,
    parameter int UNIT_CYCLES = 3200
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [31:0]       evt_main_i,
    input  logic [31:0]       evt_dma_i,
    input  logic              reg_we_i,
    input  logic [ADDR_W-1:0] reg_addr_i,
    input  logic [31:0]       reg_wdata_i,
    output logic [31:0]       reg_rdata_o,
    output logic              irq_o
);

    localparam logic [ADDR_W-1:0] A_COAL = ADDR_W'(OFS_COAL);
    localparam logic [ADDR_W-1:0] A_STAT = ADDR_W'(OFS_STAT);
    localparam logic [ADDR_W-1:0] A_MASK = ADDR_W'(OFS_MASK);
    localparam logic [ADDR_W-1:0] A_DMA  = ADDR_W'(OFS_DMA);

    logic [31:0]       main_raw, dma_raw, main_view;
    logic [31:0]       main_clr, dma_clr;
    logic [31:0]       mask_q;
    logic [COAL_W-1:0] coal_q;
    logic              pending, bypass;
    irq_state_t        fsm_state;

    assign main_clr = (reg_we_i && reg_addr_i == A_STAT) ? reg_wdata_i : '0;
    assign dma_clr  = (reg_we_i && reg_addr_i == A_DMA)  ? reg_wdata_i : '0;

    hirq_w1c_bank #(.W(32), .IMPL(MAIN_EVT_BITS)) u_main_bank (
        .clk   (clk),
        .rst_n (rst_n),
        .set_i (evt_main_i),
        .clr_i (main_clr),
        .q_o   (main_raw)
    );

    hirq_w1c_bank #(.W(32), .IMPL(DMA_BITS)) u_dma_bank (
        .clk   (clk),
        .rst_n (rst_n),
        .set_i (evt_dma_i),
        .clr_i (dma_clr),
        .q_o   (dma_raw)
    );

    // roll DMA groups up into the main view
    always_comb begin
        main_view          = main_raw;
        main_view[SUM_RX]  = |(dma_raw & DMA_RX_GRP);
        main_view[SUM_ERR] = |(dma_raw & DMA_ERR_GRP);
        main_view[SUM_TX]  = |(dma_raw & DMA_TX_GRP);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mask_q <= '0;
            coal_q <= '0;
        end else if (reg_we_i) begin
            if (reg_addr_i == A_MASK) mask_q <= reg_wdata_i;
            if (reg_addr_i == A_COAL) coal_q <= reg_wdata_i[COAL_W-1:0];
        end
    end

    assign pending = |(main_view & mask_q);
    assign bypass  = dma_raw[HIPRI_RX] & mask_q[SUM_RX];

    hirq_coal_fsm #(.COAL_W(COAL_W), .UNIT_CYCLES(UNIT_CYCLES)) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .pending_i (pending),
        .bypass_i  (bypass),
        .coal_i    (coal_q),
        .state_o   (fsm_state),
        .irq_o     (irq_o)
    );

    always_comb begin
        unique case (reg_addr_i)
            A_COAL:  reg_rdata_o = {{(32 - COAL_W){1'b0}}, coal_q};
            A_STAT:  reg_rdata_o = main_view;
            A_MASK:  reg_rdata_o = mask_q;
            A_DMA:   reg_rdata_o = dma_raw;
            default: reg_rdata_o = '0;
        endcase
    end

endmodule

// File: rtl/hirq_checker.sv
module hirq_checker
    import hirq_pkg::*;
#(
    parameter int ADDR_W = 12,
    parameter int COAL_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic [31:0]       evt_main_i,
    input logic [31:0]       evt_dma_i,
    input logic              reg_we_i,
    input logic [ADDR_W-1:0] reg_addr_i,
    input logic [31:0]       reg_wdata_i,
    input logic [31:0]       main_raw,
    input logic [31:0]       dma_raw,
    input logic [31:0]       main_view,
    input logic [31:0]       mask_q,
    input logic [COAL_W-1:0] coal_q,
    input irq_state_t        fsm_state,
    input logic              irq_o
);

    localparam logic [ADDR_W-1:0] A_STAT = ADDR_W'(OFS_STAT);

    logic wr_stat, pend, hp;
    assign wr_stat = reg_we_i && (reg_addr_i == A_STAT);
    assign pend    = |(main_view & mask_q);
    assign hp      = dma_raw[HIPRI_RX] && mask_q[SUM_RX];

    AST_SET_WINS_DMA: assert property (@(posedge clk) disable iff (!rst_n)
        (|(evt_dma_i & DMA_BITS)) |=>
        ((dma_raw & $past(evt_dma_i & DMA_BITS)) == $past(evt_dma_i & DMA_BITS))); // R2

    AST_MAIN_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_stat && evt_main_i == '0) |=> (main_raw == $past(main_raw))); // R2

    AST_W1C_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_stat && evt_main_i == '0) |=> ((main_raw & $past(reg_wdata_i)) == '0)); // R2

    AST_IRQ_NEEDS_PENDING: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |-> $past(pend)); // R7

    AST_ZERO_COAL_FAST: assert property (@(posedge clk) disable iff (!rst_n)
        (fsm_state == ST_IDLE && pend && coal_q == '0) |=> irq_o); // R8

    AST_BYPASS_FAST: assert property (@(posedge clk) disable iff (!rst_n)
        hp |=> irq_o); // R10

endmodule

bind host_irq_coalescer hirq_checker #(.ADDR_W(ADDR_W), .COAL_W(COAL_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .evt_main_i  (evt_main_i),
    .evt_dma_i   (evt_dma_i),
    .reg_we_i    (reg_we_i),
    .reg_addr_i  (reg_addr_i),
    .reg_wdata_i (reg_wdata_i),
    .main_raw    (main_raw),
    .dma_raw     (dma_raw),
    .main_view   (main_view),
    .mask_q      (mask_q),
    .coal_q      (coal_q),
    .fsm_state   (fsm_state),
    .irq_o       (irq_o)
);

// File: tb/host_irq_coalescer_bench.sv
module host_irq_coalescer_bench;

    localparam int UNIT = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] evt_main = '0, evt_dma = '0, wdata = '0;
    logic        we = 1'b0;
    logic [11:0] addr = '0;
    logic [31:0] rdata;
    logic        irq;

    host_irq_coalescer #(.ADDR_W(12), .COAL_W(8), .UNIT_CYCLES(UNIT)) u_host_irq_coalescer (
        .clk(clk), .rst_n(rst_n), .evt_main_i(evt_main), .evt_dma_i(evt_dma),
        .reg_we_i(we), .reg_addr_i(addr), .reg_wdata_i(wdata),
        .reg_rdata_o(rdata), .irq_o(irq)
    );

    always #5 clk = ~clk;

    // behavioural reference
    logic [31:0] m_main, m_dma, m_mask;
    logic [7:0]  m_coal;
    int          m_mode;   // 0 quiet, 1 waiting, 2 raised
    int          m_left;
    int          vectors = 0, misses = 0;
    bit          finished = 0;
    string       cur_req = "R1";

    function automatic logic [31:0] view_main();
        logic [31:0] v;
        v = m_main;
        v[31] = m_dma[30] | m_dma[18] | m_dma[17] | m_dma[16];
        v[29] = m_dma[31];
        v[27] = m_dma[6] | m_dma[1] | m_dma[0];
        return v;
    endfunction

    function automatic logic [31:0] model_read(input logic [11:0] a);
        case (a)
            12'h004: return {24'h0, m_coal};
            12'h008: return view_main();
            12'h00C: return m_mask;
            12'h010: return m_dma;
            default: return 32'h0;
        endcase
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            m_main = '0; m_dma = '0; m_mask = '0; m_coal = '0; m_mode = 0; m_left = 0;
        end else begin
            bit pend, hp;
            logic [31:0] clr_m, clr_d;
            pend = |(view_main() & m_mask);
            hp   = m_dma[30] && m_mask[31];
            if (m_mode == 0) begin
                if (pend) begin
                    if (m_coal == 0 || hp) m_mode = 2;
                    else begin m_mode = 1; m_left = m_coal * UNIT; end
                end
            end else if (m_mode == 1) begin
                if (!pend) m_mode = 0;
                else if (hp || m_left == 1) m_mode = 2;
                else m_left = m_left - 1;
            end else begin
                if (!pend) m_mode = 0;
            end
            clr_m = (we && addr == 12'h008) ? wdata : 32'h0;
            clr_d = (we && addr == 12'h010) ? wdata : 32'h0;
            m_main = ((m_main & ~clr_m) | evt_main) & 32'h1600_00CB;
            m_dma  = ((m_dma  & ~clr_d) | evt_dma)  & 32'hC007_0043;
            if (we && addr == 12'h00C) m_mask = wdata;
            if (we && addr == 12'h004) m_coal = wdata[7:0];
        end
    end

    task automatic compare();
        logic [31:0] exp_rd;
        exp_rd = model_read(addr);
        vectors++;
        if (irq !== (m_mode == 2)) begin
            misses++;
            $display("FAIL %s irq_o at %0t: got %0b expected %0b", cur_req, $time, irq, (m_mode == 2));
        end
        vectors++;
        if (rdata !== exp_rd) begin
            misses++;
            $display("FAIL %s rdata@%h at %0t: got %h expected %h", cur_req, addr, $time, rdata, exp_rd);
        end
    endtask

    task automatic cyc(input logic [31:0] em, input logic [31:0] ed, input logic w,
                       input logic [11:0] a, input logic [31:0] d, input string req);
        @(negedge clk);
        evt_main = em; evt_dma = ed; we = w; addr = a; wdata = d; cur_req = req;
        #1;
        compare();
    endtask

    task automatic idle(input int n, input logic [11:0] a, input string req);
        for (int i = 0; i < n; i++) cyc('0, '0, 1'b0, a, '0, req);
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1;
            $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
            $finish;
        end
    endtask

    initial begin
        #(200000 * 10);
        misses++;
        $display("FAIL watchdog expired at %0t: got running expected finished", $time);
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1: reset values
        idle(1, 12'h008, "R1");
        idle(1, 12'h004, "R1");
        idle(1, 12'h00C, "R1");
        idle(1, 12'h010, "R1");
        // R6: register map and read-back
        cyc('0, '0, 1'b1, 12'h00C, 32'hA5A5_0000, "R6");
        idle(1, 12'h00C, "R6");
        cyc('0, '0, 1'b1, 12'h004, 32'h0000_1234, "R6");
        idle(1, 12'h004, "R6");
        idle(1, 12'h014, "R6");
        idle(1, 12'h000, "R6");
        cyc('0, '0, 1'b1, 12'h00C, 32'h0, "R6");
        cyc('0, '0, 1'b1, 12'h004, 32'h0, "R6");
        // R3: main event positions
        cyc(32'hFFFF_FFFF, '0, 1'b0, 12'h008, '0, "R3");
        idle(1, 12'h008, "R3");
        // R2: W1C, zero write, set beats clear
        cyc('0, '0, 1'b1, 12'h008, 32'h0, "R2");
        idle(1, 12'h008, "R2");
        cyc('0, '0, 1'b1, 12'h008, 32'h0000_000F, "R2");
        idle(1, 12'h008, "R2");
        cyc(32'h1, '0, 1'b1, 12'h008, 32'h1, "R2");
        idle(1, 12'h008, "R2");
        // R4: DMA positions
        cyc('0, 32'hFFFF_FFFF, 1'b0, 12'h010, '0, "R4");
        idle(1, 12'h010, "R4");
        // R5: roll-up and ignored summary writes
        idle(1, 12'h008, "R5");
        cyc('0, '0, 1'b1, 12'h008, 32'hA800_0000, "R5");
        idle(1, 12'h008, "R5");
        cyc('0, '0, 1'b1, 12'h010, 32'h4007_0000, "R5");
        idle(1, 12'h008, "R5");
        cyc('0, '0, 1'b1, 12'h010, 32'hFFFF_FFFF, "R5");
        idle(1, 12'h008, "R5");
        cyc('0, '0, 1'b1, 12'h008, 32'hFFFF_FFFF, "R5");
        cyc('0, 32'h0000_0002, 1'b0, 12'h008, '0, "R5");
        idle(1, 12'h008, "R5");
        cyc('0, '0, 1'b1, 12'h010, 32'hFFFF_FFFF, "R5");
        // R8: zero coalescing
        cyc('0, '0, 1'b1, 12'h00C, 32'hFFFF_FFFF, "R8");
        cyc(32'h8, '0, 1'b0, 12'h008, '0, "R8");
        idle(4, 12'h008, "R8");
        // R7: line falls after clear; masked bits do not raise it
        cyc('0, '0, 1'b1, 12'h008, 32'h8, "R7");
        idle(3, 12'h008, "R7");
        cyc('0, '0, 1'b1, 12'h00C, 32'h0000_0008, "R7");
        cyc(32'h1, '0, 1'b0, 12'h008, '0, "R7");
        idle(5, 12'h008, "R7");
        cyc('0, '0, 1'b1, 12'h008, 32'hFFFF_FFFF, "R7");
        // R9: coalescing of 3 units
        cyc('0, '0, 1'b1, 12'h00C, 32'hFFFF_FFFF, "R9");
        cyc('0, '0, 1'b1, 12'h004, 32'h3, "R9");
        cyc(32'h2, '0, 1'b0, 12'h008, '0, "R9");
        idle(16, 12'h008, "R9");
        cyc('0, '0, 1'b1, 12'h008, 32'h2, "R9");
        idle(2, 12'h008, "R9");
        // R11: abandoned wait restarts
        cyc('0, '0, 1'b1, 12'h004, 32'h2, "R11");
        cyc(32'h1, '0, 1'b0, 12'h008, '0, "R11");
        idle(3, 12'h008, "R11");
        cyc('0, '0, 1'b1, 12'h008, 32'h1, "R11");
        idle(3, 12'h008, "R11");
        cyc(32'h1, '0, 1'b0, 12'h008, '0, "R11");
        idle(10, 12'h008, "R11");
        cyc('0, '0, 1'b1, 12'h008, 32'h1, "R11");
        idle(2, 12'h008, "R11");
        // R10: bypass cuts a running wait
        cyc('0, '0, 1'b1, 12'h004, 32'h5, "R10");
        cyc(32'h40, '0, 1'b0, 12'h008, '0, "R10");
        idle(3, 12'h008, "R10");
        cyc('0, 32'h4000_0000, 1'b0, 12'h010, '0, "R10");
        idle(3, 12'h008, "R10");
        cyc('0, '0, 1'b1, 12'h008, 32'hFFFF_FFFF, "R10");
        cyc('0, '0, 1'b1, 12'h010, 32'hFFFF_FFFF, "R10");
        idle(2, 12'h008, "R10");
        // R10: no bypass without mask bit 31
        cyc('0, '0, 1'b1, 12'h00C, 32'h0000_0040, "R10");
        cyc(32'h40, 32'h4000_0000, 1'b0, 12'h008, '0, "R10");
        idle(24, 12'h008, "R10");
        cyc('0, '0, 1'b1, 12'h008, 32'hFFFF_FFFF, "R10");
        cyc('0, '0, 1'b1, 12'h010, 32'hFFFF_FFFF, "R10");
        idle(3, 12'h010, "R10");
        finish_run();
    end

endmodule